// File: doc/BRIEF.md
# Up-Counting Event Timer with Auto-Reload

This block is a 32-bit timer peripheral on a simple register bus: address, write data and a write strobe in, combinational read data out. A free-running up-counter advances by one on every clock while the run bit is set. When it steps past all ones it either returns to zero or reloads a programmed start value. A compare value lets the counter raise a match event. Writing the negative of N into the counter makes an overflow happen after exactly N ticks, which is how software schedules a one-shot delay.

Events are kept in a sticky status register. Software clears a bit by writing 1 to it, so writing back the value it just read clears everything it saw. A per-source enable mask gates the status into a single interrupt line. Writes to control, counter, reload, trigger and match are posted. Each one raises a pending bit and takes effect only when that bit drops, two clocks later. Software polls the pending mask before issuing a dependent write.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With control bit 0 (run) set the counter rises by one per clock; with it clear the counter holds.
- R3: A running counter at all ones sets status bit 1 (overflow) and next holds the reload value if control bit 1 (auto-reload) is set, else zero.
- R4: Status bit 0 (match) is set when control bit 6 (compare enable) and run are set and the counter equals the match register; with compare disabled it is never set.
- R5: A write to the status register (0x18) clears each bit written as 1 and keeps each bit written as 0.
- R6: `irq` is high exactly when some status bit and the same bit of the enable register (0x1C) are both set; bit 0 match, bit 1 overflow, bit 2 capture.
- R7: A write to control (0x24), counter (0x28), reload (0x2C), trigger (0x30) or match (0x38) sets bit 0, 1, 2, 3 or 4 respectively of the pending mask (0x34) for two clocks; the written value takes effect as the bit clears.
- R8: Any write to the trigger register loads the counter from the reload register.
- R9: Loading the counter with the two's-complement of N and running without auto-reload gives all ones after N-1 clocks and zero with the overflow flag after N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Counting is swept over run lengths of 1 to 12 clocks and then held, which separates a counter that increments from one that skips or keeps running after stop. Overflow is swept over N = 1 to 6 ticks from a negative preload, with and without auto-reload. This separates an off-by-one in the terminal count from a wrong wrap target. Match is tried with compare on and off at a fixed distance, and the interrupt line is swept over all eight enable masks against a lone match and a lone overflow flag, exposing any crossed bit position. Posted writes are observed clock by clock in the pending mask and against the counter value, which catches a wrong delay or an effect that lands early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // posted-write slots; index is the bit in the pending mask
  localparam int NSLOT   = 5;
  localparam int SL_CTRL = 0;
  localparam int SL_CNT  = 1;
  localparam int SL_RLD  = 2;
  localparam int SL_TRG  = 3;
  localparam int SL_MAT  = 4;

  // event sources; index is the bit in status and enable
  localparam int NSRC    = 3;
  localparam int SRC_MAT = 0;
  localparam int SRC_OVF = 1;
  localparam int SRC_CAP = 2;

  // control bits
  localparam int CB_RUN = 0;
  localparam int CB_AR  = 1;
  localparam int CB_CMP = 6;

  localparam logic [7:0] OFS_STS  = 8'h18;
  localparam logic [7:0] OFS_IEN  = 8'h1C;
  localparam logic [7:0] OFS_CTRL = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h28;
  localparam logic [7:0] OFS_RLD  = 8'h2C;
  localparam logic [7:0] OFS_TRG  = 8'h30;
  localparam logic [7:0] OFS_PEND = 8'h34;
  localparam logic [7:0] OFS_MAT  = 8'h38;

  function automatic logic [7:0] slot_ofs(input int s);
    case (s)
      SL_CTRL: return OFS_CTRL;
      SL_CNT:  return OFS_CNT;
      SL_RLD:  return OFS_RLD;
      SL_TRG:  return OFS_TRG;
      default: return OFS_MAT;
    endcase
  endfunction
endpackage

// File: rtl/tmr_posted.sv
module tmr_posted #(
  parameter int DW  = 32,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic          apply,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] left_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      data_q <= '0;
    end else if (wr) begin
      left_q <= CW'(DLY);
      data_q <= wdata;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pend  = (left_q != '0);
  assign apply = (left_q == CW'(1)) && !wr;
  assign data  = data_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          autoreload,
  input  logic          cmp_en,
  input  logic [DW-1:0] reload,
  input  logic [DW-1:0] match_val,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          trg,
  output logic [DW-1:0] cnt,
  output logic          ovf_evt,
  output logic          match_evt
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  function automatic logic [DW-1:0] step(input logic [DW-1:0] c,
                                         input logic [DW-1:0] r,
                                         input logic ar);
    if (c == TOP) return ar ? r : '0;
    return c + 1'b1;
  endfunction

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld)     cnt_q <= ld_val;
    else if (trg)    cnt_q <= reload;
    else if (run)    cnt_q <= step(cnt_q, reload, autoreload);
  end

  assign ovf_evt   = run && !ld && !trg && (cnt_q == TOP);
  assign match_evt = run && cmp_en && (cnt_q == match_val);
  assign cnt       = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sts_wr,
  input  logic            ien_wr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] set_vec,
  output logic [NSRC-1:0] sts,
  output logic [NSRC-1:0] ien,
  output logic            irq
);
  logic [NSRC-1:0] sts_q, ien_q, clr;

  assign clr = sts_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_vec;
      if (ien_wr) ien_q <= wdata;
    end
  end

  assign sts = sts_q;
  assign ien = ien_q;
  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [NSLOT-1:0] slot_wr, pend_w, slot_ap;
  logic [DW-1:0]    slot_d [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_wr[i] = bus_we && (bus_addr == AW'(slot_ofs(i)));
    tmr_posted #(.DW(DW), .DLY(DLY)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(slot_wr[i]), .wdata(bus_wdata),
      .pend(pend_w[i]), .apply(slot_ap[i]), .data(slot_d[i])
    );
  end

  // committed copies of the posted configuration registers
  logic [DW-1:0] ctrl_q, rld_q, mat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      mat_q  <= '0;
    end else begin
      if (slot_ap[SL_CTRL]) ctrl_q <= slot_d[SL_CTRL];
      if (slot_ap[SL_RLD])  rld_q  <= slot_d[SL_RLD];
      if (slot_ap[SL_MAT])  mat_q  <= slot_d[SL_MAT];
    end
  end

  logic          cnt_ld, trg_ld, ovf_evt, match_evt;
  logic [DW-1:0] cnt_w;
  assign cnt_ld = slot_ap[SL_CNT];
  assign trg_ld = slot_ap[SL_TRG];

  tmr_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q[CB_RUN]), .autoreload(ctrl_q[CB_AR]), .cmp_en(ctrl_q[CB_CMP]),
    .reload(rld_q), .match_val(mat_q),
    .ld(cnt_ld), .ld_val(slot_d[SL_CNT]), .trg(trg_ld),
    .cnt(cnt_w), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  logic [NSRC-1:0] set_vec, sts_w, ien_w;
  always_comb begin
    set_vec          = '0;
    set_vec[SRC_MAT] = match_evt;
    set_vec[SRC_OVF] = ovf_evt;
    set_vec[SRC_CAP] = 1'b0;
  end

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .sts_wr(bus_we && (bus_addr == AW'(OFS_STS))),
    .ien_wr(bus_we && (bus_addr == AW'(OFS_IEN))),
    .wdata(bus_wdata[NSRC-1:0]), .set_vec(set_vec),
    .sts(sts_w), .ien(ien_w), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      AW'(OFS_STS):  bus_rdata = DW'(sts_w);
      AW'(OFS_IEN):  bus_rdata = DW'(ien_w);
      AW'(OFS_CTRL): bus_rdata = ctrl_q;
      AW'(OFS_CNT):  bus_rdata = cnt_w;
      AW'(OFS_RLD):  bus_rdata = rld_q;
      AW'(OFS_TRG):  bus_rdata = slot_d[SL_TRG];
      AW'(OFS_PEND): bus_rdata = DW'(pend_w);
      AW'(OFS_MAT):  bus_rdata = mat_q;
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] cnt_w,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] rld_q,
  input logic          cnt_ld,
  input logic          trg_ld,
  input logic          ovf_evt,
  input logic          match_evt,
  input logic [2:0]    sts_w,
  input logic [4:0]    pend_w,
  input logic          irq
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !cnt_ld && !trg_ld && cnt_w != {DW{1'b1}})
      |=> cnt_w == $past(cnt_w) + DW'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !cnt_ld && !trg_ld) |=> $stable(cnt_w));

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sts_w[1]);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_w == ($past(ctrl_q[1]) ? $past(rld_q) : '0));

  p_match_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> sts_w[0]);

  p_quiet_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w == 3'b000) |-> !irq);

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_w[1]) |=> pend_w[1]);

  p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> !pend_w[1]);

  p_trigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_ld && !cnt_ld) |=> cnt_w == $past(rld_q));
endmodule

bind tick_timer tmr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_w(cnt_w), .ctrl_q(ctrl_q), .rld_q(rld_q),
  .cnt_ld(cnt_ld), .trg_ld(trg_ld), .ovf_evt(ovf_evt), .match_evt(match_evt),
  .sts_w(sts_w), .pend_w(pend_w), .irq(irq)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam logic [7:0] A_STS = 8'h18, A_IEN = 8'h1C, A_CTRL = 8'h24,
                         A_CNT = 8'h28, A_RLD = 8'h2C, A_TRG = 8'h30,
                         A_PEND = 8'h34, A_MAT = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    idle(2);
  endtask

  task automatic halt_and_clear();
    wr(A_CTRL, 32'h0); settle();
    wr(A_STS, 32'h7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 8'h18; a <= 8'h38; a += 4) begin
      rd(8'(a), v); chk($sformatf("R1 reg 0x%0h", a), v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R7: counter write is posted for two clocks
    wr(A_CNT, 32'd100);
    rd(A_PEND, v); chk("R7 pend cnt t0", v, 32'h2);
    rd(A_CNT, v);  chk("R7 cnt early t0", v, 32'h0);
    idle(1);
    rd(A_PEND, v); chk("R7 pend cnt t1", v, 32'h2);
    rd(A_CNT, v);  chk("R7 cnt early t1", v, 32'h0);
    idle(1);
    rd(A_PEND, v); chk("R7 pend cnt clear", v, 32'h0);
    rd(A_CNT, v);  chk("R7 cnt applied", v, 32'd100);
    wr(A_MAT, 32'd5);  rd(A_PEND, v); chk("R7 pend match", v, 32'h10); settle();
    wr(A_CTRL, 32'h0); rd(A_PEND, v); chk("R7 pend ctrl", v, 32'h1);  settle();
    wr(A_RLD, 32'd777); rd(A_PEND, v); chk("R7 pend reload", v, 32'h4); settle();

    // R8: trigger loads reload value
    wr(A_TRG, 32'hABCD);
    rd(A_PEND, v); chk("R8 pend trigger", v, 32'h8);
    settle();
    rd(A_CNT, v); chk("R8 trigger load", v, 32'd777);

    // R2: counting sweep, then hold
    wr(A_CTRL, 32'h1); settle();
    rd(A_CNT, c0);
    for (int m = 1; m <= 12; m++) begin
      idle(1); rd(A_CNT, v); chk($sformatf("R2 count +%0d", m), v, c0 + 32'(m));
    end
    wr(A_CTRL, 32'h0); settle();
    rd(A_CNT, c0); idle(10); rd(A_CNT, v); chk("R2 hold", v, c0);

    // R3 / R9: overflow after N ticks, with and without auto-reload
    for (int ar = 0; ar < 2; ar++) begin
      for (int n = 1; n <= 6; n++) begin
        halt_and_clear();
        wr(A_RLD, 32'(1000 + n)); settle();
        wr(A_CNT, -32'(n)); settle();
        wr(A_CTRL, ar ? 32'h3 : 32'h1); settle();
        idle(n - 1);
        rd(A_CNT, v); chk($sformatf("R9 all ones ar=%0d n=%0d", ar, n), v, 32'hFFFF_FFFF);
        rd(A_STS, v); chk($sformatf("R3 no flag yet ar=%0d n=%0d", ar, n), v, 32'h0);
        idle(1);
        rd(A_CNT, v);
        chk($sformatf("R3 wrap target ar=%0d n=%0d", ar, n), v, ar ? 32'(1000 + n) : 32'h0);
        rd(A_STS, v); chk($sformatf("R9 overflow flag ar=%0d n=%0d", ar, n), v, 32'h2);
      end
    end

    // R5: write-one-to-clear
    wr(A_CTRL, 32'h0); settle();
    rd(A_STS, v); chk("R5 flag present", v, 32'h2);
    wr(A_STS, 32'h1); rd(A_STS, v); chk("R5 zero keeps", v, 32'h2);
    wr(A_STS, 32'h5); rd(A_STS, v); chk("R5 other ones keep", v, 32'h2);

    // R6: enable sweep against a lone overflow flag
    for (int e = 0; e < 8; e++) begin
      wr(A_IEN, 32'(e));
      chk($sformatf("R6 ovf en=%0d", e), {31'h0, irq}, {31'h0, e[1]});
    end
    wr(A_STS, 32'h2); rd(A_STS, v); chk("R5 clear ovf", v, 32'h0);
    chk("R6 irq after clear", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h0);

    // R4: match with compare enabled
    halt_and_clear();
    wr(A_MAT, 32'd55); wr(A_CNT, 32'd50); settle();
    wr(A_CTRL, 32'h41); settle();
    idle(5);
    rd(A_CNT, v); chk("R4 at match value", v, 32'd55);
    rd(A_STS, v); chk("R4 not yet", v, 32'h0);
    idle(1);
    rd(A_STS, v); chk("R4 match flag", v, 32'h1);
    wr(A_CTRL, 32'h0); settle();

    // R6: enable sweep against a lone match flag
    for (int e = 0; e < 8; e++) begin
      wr(A_IEN, 32'(e));
      chk($sformatf("R6 match en=%0d", e), {31'h0, irq}, {31'h0, e[0]});
    end
    wr(A_IEN, 32'h0);

    // R4: compare disabled never flags
    halt_and_clear();
    wr(A_CNT, 32'd50); settle();
    wr(A_CTRL, 32'h1); settle();
    idle(10);
    rd(A_STS, v); chk("R4 compare off", v, 32'h0);
    wr(A_CTRL, 32'h0); settle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule